// File: doc/BRIEF.md
# Interleaved Inverse 5/3 Wavelet Synthesis Filter

This block rebuilds a one-dimensional signal from a single stream of 5/3 wavelet coefficients. The low-band and high-band coefficients arrive interleaved: the low band takes the even positions and the high band the odd positions. The block accepts one coefficient per clock and returns one reconstructed sample per clock, already in natural order. It does not upsample each band and filter the bands apart. A parity bit flips with every accepted coefficient and picks one of two tap sets, and both tap sets read the same four-deep history of past coefficients. No cycle is spent on inserted zeros, and no final adder merges two branch outputs.

Samples are two's complement fixed point with 24 bits and 12 fractional bits by default. Every coefficient is a power of two or a sum of two powers of two, so the arithmetic is made of fixed shifts and adders only. The sum is formed with three extra fractional bits and then cut back to the sample grid by truncation. The block expects its input to come from the matching forward 5/3 analysis filter, starting at index 0 after reset. Under that condition the output reproduces the original signal four samples late. Edge extension at the ends of the signal is left to the surrounding logic.

Top module: `iwt53_tm`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is 0. Reset also clears the coefficient history to zero and sets the parity to even.
- R2: The first coefficient accepted after reset is index 0, which is even. The parity flips on every accepted coefficient, that is, on every cycle with in_valid_i=1, and on no other cycle.
- R3: For a coefficient accepted at an even index n, the output is w = -1/4·y[n-1] + y[n-2] - 1/4·y[n-3].
- R4: For a coefficient accepted at an odd index n, the output is w = -1/8·y[n] + 1/2·y[n-1] + 3/4·y[n-2] + 1/2·y[n-3] - 1/8·y[n-4].
- R5: The value w for the coefficient accepted at a rising edge appears on out_data_o right after that same edge. This holds for every accepted coefficient, including those accepted during the fill period.
- R6: out_valid_o is 1 in the cycle after an accepted coefficient exactly when at least four coefficients were accepted before it since reset. Otherwise out_valid_o is 0.
- R7: A cycle with in_valid_i=0 does not shift the history and does not flip the parity. In the next cycle out_valid_o is 0 and out_data_o holds its value.
- R8: The result is 8·w computed exactly, then shifted right arithmetically by 3 and wrapped to DATA_W bits. This truncates toward minus infinity. For example, 8·w = -1 gives out_data_o = all ones.
- R9: Feed the block the forward 5/3 coefficients of a signal x, with x[k]=0 for k<0. The output for input index n is then exactly x[n-4], and an unbroken input stream gives a valid output every cycle once the fill period is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Coefficient on in_data_i is accepted this cycle |
| in_data_i | input | DATA_W | Interleaved coefficient, low band on even index, high band on odd index |
| out_valid_o | output | 1 | out_data_o holds a reconstructed sample |
| out_data_o | output | DATA_W | Reconstructed sample, natural order |

## Verification
The assertions assume that in_valid_i is always 0 or 1, never unknown. They also assume that the stream seen after each reset starts at even index 0. With those two conditions, the parity and the fill count can be rebuilt from in_valid_i alone. The bench drives only known values, starting at a falling edge, and it resets the block before every scenario, so every stream begins on an even index. It picks test signals in steps of 64 LSBs with small amplitude. This keeps the forward coefficients exact and inside the sample range, so the four-sample delayed copy is an exact comparison.

// File: rtl/iwt53_pkg.sv
package iwt53_pkg;
  // extra fractional bits: the smallest coefficient is 1/8
  localparam int unsigned GUARD_BITS = 3;
  // history depth used by the high-band tap set
  localparam int unsigned TAP_DEPTH  = 4;
  // samples to accept before the first valid output
  localparam int unsigned FILL_LEN   = 4;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/iwt53_phase_ctrl.sv
module iwt53_phase_ctrl
  import iwt53_pkg::*;
#(
  parameter int unsigned FILL = FILL_LEN
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  output phase_e phase_o,
  output logic   primed_o
);
  localparam int unsigned CNT_W = $clog2(FILL + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      fill_q  <= '0;
    end else if (step_i) begin
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      if (fill_q != CNT_W'(FILL)) fill_q <= fill_q + 1'b1;
    end
  end

  assign phase_o  = phase_q;
  assign primed_o = (fill_q == CNT_W'(FILL));
endmodule

// File: rtl/iwt53_tap_line.sv
module iwt53_tap_line #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          step_i,
  input  logic [DATA_W-1:0]             d_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps_o
);
  // taps_o[k] holds y[n-1-k] relative to the sample currently on d_i
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] stage_d;

    if (g == 0) begin : g_head
      assign stage_d = d_i;
    end else begin : g_body
      assign stage_d = taps_o[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q <= '0;
      else if (step_i) stage_q <= stage_d;
    end

    assign taps_o[g] = stage_q;
  end
endmodule

// File: rtl/iwt53_tap_sum.sv
module iwt53_tap_sum
  import iwt53_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  phase_e                             phase_i,
  input  logic [DATA_W-1:0]                  cur_i,
  input  logic [TAP_DEPTH-1:0][DATA_W-1:0]   taps_i,
  output logic [DATA_W-1:0]                  w_o
);
  // 8*w needs GUARD_BITS more bits, plus 2 bits for coefficient gain
  localparam int unsigned ACC_W = DATA_W + GUARD_BITS + 2;

  logic signed [ACC_W-1:0] x0;
  logic signed [ACC_W-1:0] t0, t1, t2, t3;
  logic signed [ACC_W-1:0] acc_lo, acc_hi, acc;

  assign x0 = ACC_W'(signed'(cur_i));
  assign t0 = ACC_W'(signed'(taps_i[0]));
  assign t1 = ACC_W'(signed'(taps_i[1]));
  assign t2 = ACC_W'(signed'(taps_i[2]));
  assign t3 = ACC_W'(signed'(taps_i[3]));

  // even slot: 8w = -2 y1 + 8 y2 - 2 y3
  assign acc_lo = (t1 <<< 3) - (t0 <<< 1) - (t2 <<< 1);
  // odd slot: 8w = -y0 + 4 y1 + 6 y2 + 4 y3 - y4
  assign acc_hi = (t0 <<< 2) + (t1 <<< 2) + (t1 <<< 1) + (t2 <<< 2) - x0 - t3;

  assign acc = (phase_i == PH_HIGH) ? acc_hi : acc_lo;
  assign w_o = DATA_W'(acc >>> GUARD_BITS);
endmodule

// File: rtl/iwt53_tm.sv
module iwt53_tm
  import iwt53_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  phase_e                           phase_w;
  logic                             primed_w;
  logic [TAP_DEPTH-1:0][DATA_W-1:0] taps_w;
  logic [DATA_W-1:0]                w_w;
  logic                             valid_q;
  logic [DATA_W-1:0]                data_q;

  iwt53_phase_ctrl #(.FILL(FILL_LEN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (in_valid_i),
    .phase_o  (phase_w),
    .primed_o (primed_w)
  );

  iwt53_tap_line #(.DATA_W(DATA_W), .DEPTH(TAP_DEPTH)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (in_valid_i),
    .d_i    (in_data_i),
    .taps_o (taps_w)
  );

  iwt53_tap_sum #(.DATA_W(DATA_W)) u_sum (
    .phase_i (phase_w),
    .cur_i   (in_data_i),
    .taps_i  (taps_w),
    .w_o     (w_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid_i & primed_w;
      if (in_valid_i) data_q <= w_w;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/iwt53_tm_chk.sv
module iwt53_tm_chk
  import iwt53_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned FILL   = FILL_LEN
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input phase_e            phase_i
);
  localparam int unsigned CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] seen_q;
  logic             par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      par_q  <= 1'b0;
    end else if (in_valid_i) begin
      par_q <= ~par_q;
      if (seen_q != CNT_W'(FILL)) seen_q <= seen_q + 1'b1;
    end
  end

  a_r2_phase_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HIGH) == par_q);

  a_r6_valid_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && seen_q == CNT_W'(FILL)) |=> out_valid_o);

  a_r6_quiet_during_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && seen_q != CNT_W'(FILL)) |=> !out_valid_o);

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(out_data_o)));
endmodule

bind iwt53_tm iwt53_tm_chk #(.DATA_W(DATA_W), .FILL(iwt53_pkg::FILL_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .phase_i     (phase_w)
);

// File: tb/iwt53_tm_tb.sv
`timescale 1ns/1ps
module iwt53_tm_tb;
  localparam int unsigned W = 24;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state, built from the requirement formulas
  longint mh[4];
  int     m_cnt;
  bit     m_par;
  // forward-filter history for reconstruction
  longint xh[0:4];
  longint xs[$];

  always #2 clk = ~clk;

  iwt53_tm #(.DATA_W(W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni   = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_data == '0, "R1 data in reset", out_data, 0);
    for (int i = 0; i < 4; i++) mh[i] = 0;
    for (int i = 0; i < 5; i++) xh[i] = 0;
    m_cnt = 0;
    m_par = 1'b0;
    rst_ni = 1'b1;
  endtask

  // push one coefficient, check R3/R4/R5/R6 against the model
  task automatic push(input logic [W-1:0] y);
    longint ys, acc8, e;
    bit     ev;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = y;
    ys = longint'($signed(y));
    if (m_par) acc8 = -ys + 4*mh[0] + 6*mh[1] + 4*mh[2] - mh[3];
    else       acc8 = -2*mh[0] + 8*mh[1] - 2*mh[2];
    e  = acc8 >>> 3;
    ev = (m_cnt >= 4);
    mh[3] = mh[2]; mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = ys;
    if (m_cnt < 4) m_cnt++;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == ev, "R6 valid", out_valid, ev);
    chk(out_data == e[W-1:0], m_par ? "R4 odd taps" : "R3 even taps", out_data, e[W-1:0]);
    m_par = ~m_par;
  endtask

  task automatic idle(input int n);
    logic [W-1:0] held;
    held = out_data;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle valid", out_valid, 0);
      chk(out_data == held, "R7 idle hold", out_data, held);
    end
  endtask

  // forward 5/3 analysis of x, then push and compare with x[n-4]
  task automatic push_x(input longint x, input int n);
    longint y8;
    xh[4] = xh[3]; xh[3] = xh[2]; xh[2] = xh[1]; xh[1] = xh[0]; xh[0] = x;
    xs.push_back(x);
    if (n % 2 == 0) y8 = -xh[0] + 2*xh[1] + 6*xh[2] + 2*xh[3] - xh[4];
    else            y8 = -4*xh[1] + 8*xh[2] - 4*xh[3];
    push(W'(y8 / 8));
    if (n >= 4) chk(longint'($signed(out_data)) == xs[n-4], "R9 reconstruct",
                    longint'($signed(out_data)), xs[n-4]);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < 4; i++) push(24'h000100);
    chk(out_valid == 1'b0, "R6 still filling", out_valid, 0);
    push(24'h000100);
    chk(out_valid == 1'b1, "R6 first valid", out_valid, 1);
  endtask

  task automatic t_impulse();
    do_reset();
    for (int i = 0; i < 4; i++) push('0);
    push(24'h001000);                                         // index 4, even
    push('0); chk(out_data == 24'h000800, "R4 low-band 1/2", out_data, 24'h000800);
    push('0); chk(out_data == 24'h001000, "R3 low-band 1", out_data, 24'h001000);
    push('0); chk(out_data == 24'h000800, "R4 low-band 1/2 tail", out_data, 24'h000800);
    push(24'h001000);                                         // index 8, even
    push(24'h001000);                                         // index 9, odd
    do_reset();
    for (int i = 0; i < 5; i++) push('0);
    push(24'h001000);                                         // index 5, odd
    chk(out_data == 24'hFFFE00, "R4 high-band -1/8", out_data, 24'hFFFE00);
    push('0); chk(out_data == 24'hFFFC00, "R3 high-band -1/4", out_data, 24'hFFFC00);
    push('0); chk(out_data == 24'h000C00, "R4 high-band 3/4", out_data, 24'h000C00);
    push('0); chk(out_data == 24'hFFFC00, "R3 high-band -1/4 tail", out_data, 24'hFFFC00);
    push('0); chk(out_data == 24'hFFFE00, "R4 high-band -1/8 tail", out_data, 24'hFFFE00);
  endtask

  task automatic t_trunc();
    do_reset();
    for (int i = 0; i < 5; i++) push('0);
    push(24'h000001);                                         // odd: 8w = -1
    chk(out_data == 24'hFFFFFF, "R8 floor odd", out_data, 24'hFFFFFF);
    push('0);                                                 // even: 8w = -2
    chk(out_data == 24'hFFFFFF, "R8 floor even", out_data, 24'hFFFFFF);
    push('0);                                                 // odd: 8w = 6
    chk(out_data == 24'h000000, "R8 floor positive", out_data, 0);
  endtask

  task automatic t_random_taps();
    do_reset();
    for (int i = 0; i < 60; i++) push(W'($urandom));
  endtask

  task automatic t_stall_and_parity();
    do_reset();
    push(24'h001000);                                         // index 0 even
    idle(3);
    push('0);                                                 // index 1 must be odd
    chk(out_data == 24'h000800, "R2 parity kept over idle", out_data, 24'h000800);
    push('0); push('0); push('0);
    idle(2);
    push(24'h000200);
  endtask

  task automatic t_cascade(input bit gaps);
    do_reset();
    xs.delete();
    for (int n = 0; n < 48; n++) begin
      push_x(64 * (longint'($urandom_range(1023)) - 512), n);
      if (gaps && (n % 7 == 3)) idle(2);
    end
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 7; i++) push(W'($urandom));
    do_reset();
    push(24'h001000);
    chk(out_valid == 1'b0, "R1 fill restarts", out_valid, 0);
    push('0);
    chk(out_data == 24'h000800, "R2 index 0 after reset", out_data, 24'h000800);
  endtask

  initial begin
    t_fill();
    t_impulse();
    t_trunc();
    t_random_taps();
    t_stall_and_parity();
    t_cascade(1'b0);
    t_cascade(1'b1);
    t_midreset();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      summary();
    end
  end
endmodule